// File: doc/BRIEF.md
# DRAM Mode Register Programming Unit

This unit sits inside the device model of a four-bank double-data-rate graphics DRAM and owns its two configuration registers. It watches the registered command strobes together with the address bus and the low bank-address bit. When the strobes encode a register write, the unit checks whether the device may accept it, decodes the fields and keeps them. It drives the derived latencies and the option control bits to the rest of the device. The bank-address bit picks the target: 0 selects the primary mode register (CAS latency, burst settings, write recovery, test mode), and 1 selects the extended register (termination, additive latency, strobe type, DLL enable, driver strength).

Acceptance is guarded by a small two-state machine. In state READY a write is accepted if the bank controller reports that every bank is idle. The transition READY to HOLD happens on each accepted write. HOLD keeps `busy` high and rejects further writes until its countdown expires. The transition HOLD to READY then reopens the gate, so the next command can be taken `BUSY_CYC` clock edges after the accepted one.

A field that carries a reserved code keeps its previous value and raises a sticky error flag. The flag clears only at reset. A valid indication goes high once each register has taken at least one write.

Top module: `mrs_prog_unit`

## Requirements
- R1: A register write is decoded only when `cs_n`, `ras_n`, `cas_n` and `we_n` are all low at a rising clock edge. Any other combination changes no stored field and does not start the busy window.
- R2: With `ba_sel`=0 the write goes to the primary register. With `ba_sel`=1 it goes to the extended register. A write to one register leaves every field of the other unchanged.
- R3: Primary bits [6:4] give CAS latency: 101=5, 110=6, 111=7. Any other code keeps the previous `cas_lat` and sets `illegal_mode`.
- R4: Primary bits [2:0] must be 010 (burst of four) and bit [3] must be 0 (sequential). If not, `illegal_mode` is set, and the other legal fields of that same write still update.
- R5: Primary bits [11:9] give write recovery: 010=3, 011=4, 100=5 cycles. Any other code keeps the previous `wr_recovery` and sets `illegal_mode`.
- R6: Primary bit [7] is copied to `test_mode` (1 = test, 0 = normal).
- R7: Extended write fields map as follows:
  - bits [1:0] to `ca_term` (00 off, 01 x1, 10 x2, 11 x4);
  - bits [3:2] to `term_mode` (00 off, 01 calibration, 10 60 ohm, 11 120 ohm);
  - bit [4] to `add_lat`;
  - bit [5] to `strobe_single` (0 differential);
  - bit [6] to `dll_on`;
  - bits [9:7] to `drv_sel`;
  - bit [10] to `rd_term_off`.

  All extended codes are legal.
- R8: `read_lat` always equals `cas_lat + add_lat`, and `write_lat` always equals `add_lat + 1`.
- R9: A write decoded while `banks_idle` is low is ignored.
- R10: After a write accepted at edge k, `busy` is high for three cycles (BUSY_CYC-1). Writes at edges k+1 to k+3 are ignored, and a write at edge k+4 is accepted.
- R11: `illegal_mode` stays high once set, until reset.
- R12: `mode_valid` is low until both registers have each accepted at least one write, and stays high after that.
- R13: After reset: `cas_lat`=5, `wr_recovery`=3, `busy`=0, `illegal_mode`=0, `mode_valid`=0, and all other option bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Registered chip select, active low |
| ras_n | input | 1 | Registered row strobe, active low |
| cas_n | input | 1 | Registered column strobe, active low |
| we_n | input | 1 | Registered write enable, active low |
| ba_sel | input | 1 | Low bank-address bit, register select |
| addr | input | ADDR_W | Address bus carrying the opcode |
| banks_idle | input | 1 | High when every bank is precharged |
| cas_lat | output | 3 | CAS latency in cycles |
| wr_recovery | output | 3 | Write recovery in cycles |
| test_mode | output | 1 | Test mode select |
| ca_term | output | 2 | Command/address termination ratio |
| term_mode | output | 2 | Data termination mode |
| add_lat | output | 1 | Additive latency |
| strobe_single | output | 1 | Single-ended strobe select |
| dll_on | output | 1 | DLL enable |
| drv_sel | output | 3 | Output driver strength code |
| rd_term_off | output | 1 | Data termination off during reads |
| read_lat | output | 4 | Derived read latency |
| write_lat | output | 2 | Derived write latency |
| busy | output | 1 | Busy window after a write |
| illegal_mode | output | 1 | Sticky reserved-code flag |
| mode_valid | output | 1 | Both registers have been programmed |

## Verification
The bound checker watches every cycle for the following:
- the latency relation;
- the legal ranges of CAS latency and write recovery;
- the stickiness of the error and valid flags;
- the rule that nothing stored moves while banks are busy or while the busy window rejects a write.

Only the bench scenarios can show the actual decoding:
- the exact field mappings, including that a reserved code keeps the old value while its legal neighbours update;
- the precise edge at which the busy window reopens;
- that non-write strobe patterns are ignored.

A reference model in the bench covers these over mixed random and directed traffic.

// File: rtl/mrsu_pkg.sv
package mrsu_pkg;

    typedef enum logic [0:0] {
        ST_READY = 1'b0,
        ST_HOLD  = 1'b1
    } gate_state_e;

    typedef struct packed {
        logic [2:0] cas_lat;
        logic [2:0] wr_rec;
        logic       test_mode;
    } mode_fields_t;

    typedef struct packed {
        logic [1:0] ca_term;
        logic [1:0] term_mode;
        logic       add_lat;
        logic       strobe_single;
        logic       dll_on;
        logic [2:0] drv_sel;
        logic       rd_term_off;
    } ext_fields_t;

    localparam logic [2:0] CL_RESET = 3'd5;
    localparam logic [2:0] WR_RESET = 3'd3;

endpackage

// File: rtl/mrsu_cmd_decode.sv
module mrsu_cmd_decode (
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic ba_sel,
    input  logic banks_idle,
    input  logic gate_open,
    output logic load_mode,
    output logic load_ext
);
    logic reg_write;
    logic allowed;

    always_comb begin
        reg_write = !cs_n && !ras_n && !cas_n && !we_n;
        allowed   = reg_write && banks_idle && gate_open;
        load_mode = allowed && !ba_sel;
        load_ext  = allowed && ba_sel;
    end
endmodule

// File: rtl/mrsu_gate_fsm.sv
module mrsu_gate_fsm
    import mrsu_pkg::*;
#(
    parameter int BUSY_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    output logic gate_open,
    output logic busy
);
    localparam int CW = (BUSY_CYC > 2) ? $clog2(BUSY_CYC) : 1;
    localparam logic [CW-1:0] LOAD = CW'(BUSY_CYC - 2);

    gate_state_e      state, state_nxt;
    logic [CW-1:0]    cnt, cnt_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_READY;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            ST_READY: begin
                if (accept) begin
                    state_nxt = ST_HOLD;
                    cnt_nxt   = LOAD;
                end
            end
            ST_HOLD: begin
                if (cnt == '0) state_nxt = ST_READY;
                else           cnt_nxt   = cnt - CW'(1);
            end
        endcase
    end

    always_comb begin
        gate_open = (state == ST_READY);
        busy      = (state == ST_HOLD);
    end
endmodule

// File: rtl/mrsu_field_store.sv
module mrsu_field_store
    import mrsu_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_mode,
    input  logic         load_ext,
    input  logic [11:0]  op,
    output mode_fields_t mode_q,
    output ext_fields_t  ext_q,
    output logic         illegal,
    output logic         both_seen
);
    logic bl_ok, bt_ok, cl_ok, wr_ok;
    logic seen_mode, seen_ext;

    always_comb begin
        bl_ok = (op[2:0] == 3'b010);
        bt_ok = !op[3];
        cl_ok = op[6] && (op[5:4] != 2'b00);
        wr_ok = (op[11:9] >= 3'd2) && (op[11:9] <= 3'd4);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= '{cas_lat: CL_RESET, wr_rec: WR_RESET, test_mode: 1'b0};
            ext_q     <= '0;
            illegal   <= 1'b0;
            seen_mode <= 1'b0;
            seen_ext  <= 1'b0;
        end else begin
            if (load_mode) begin
                seen_mode        <= 1'b1;
                mode_q.test_mode <= op[7];
                if (cl_ok) mode_q.cas_lat <= op[6:4];
                if (wr_ok) mode_q.wr_rec  <= op[11:9] + 3'd1;
                if (!(bl_ok && bt_ok && cl_ok && wr_ok)) illegal <= 1'b1;
            end
            if (load_ext) begin
                seen_ext            <= 1'b1;
                ext_q.ca_term       <= op[1:0];
                ext_q.term_mode     <= op[3:2];
                ext_q.add_lat       <= op[4];
                ext_q.strobe_single <= op[5];
                ext_q.dll_on        <= op[6];
                ext_q.drv_sel       <= op[9:7];
                ext_q.rd_term_off   <= op[10];
            end
        end
    end

    assign both_seen = seen_mode && seen_ext;
endmodule

// File: rtl/mrs_prog_unit.sv
module mrs_prog_unit
    import mrsu_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int BUSY_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              ba_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic              banks_idle,
    output logic [2:0]        cas_lat,
    output logic [2:0]        wr_recovery,
    output logic              test_mode,
    output logic [1:0]        ca_term,
    output logic [1:0]        term_mode,
    output logic              add_lat,
    output logic              strobe_single,
    output logic              dll_on,
    output logic [2:0]        drv_sel,
    output logic              rd_term_off,
    output logic [3:0]        read_lat,
    output logic [1:0]        write_lat,
    output logic              busy,
    output logic              illegal_mode,
    output logic              mode_valid
);
    logic         gate_open;
    logic         load_mode, load_ext;
    mode_fields_t mode_q;
    ext_fields_t  ext_q;

    mrsu_cmd_decode u_dec (
        .cs_n       (cs_n),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .we_n       (we_n),
        .ba_sel     (ba_sel),
        .banks_idle (banks_idle),
        .gate_open  (gate_open),
        .load_mode  (load_mode),
        .load_ext   (load_ext)
    );

    mrsu_gate_fsm #(.BUSY_CYC(BUSY_CYC)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (load_mode || load_ext),
        .gate_open (gate_open),
        .busy      (busy)
    );

    mrsu_field_store u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_mode (load_mode),
        .load_ext  (load_ext),
        .op        (addr[11:0]),
        .mode_q    (mode_q),
        .ext_q     (ext_q),
        .illegal   (illegal_mode),
        .both_seen (mode_valid)
    );

    always_comb begin
        cas_lat       = mode_q.cas_lat;
        wr_recovery   = mode_q.wr_rec;
        test_mode     = mode_q.test_mode;
        ca_term       = ext_q.ca_term;
        term_mode     = ext_q.term_mode;
        add_lat       = ext_q.add_lat;
        strobe_single = ext_q.strobe_single;
        dll_on        = ext_q.dll_on;
        drv_sel       = ext_q.drv_sel;
        rd_term_off   = ext_q.rd_term_off;
        read_lat      = {1'b0, mode_q.cas_lat} + {3'b000, ext_q.add_lat};
        write_lat     = {1'b0, ext_q.add_lat} + 2'd1;
    end
endmodule

// File: rtl/mrs_prog_unit_chk.sv
module mrs_prog_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       ras_n,
    input logic       cas_n,
    input logic       we_n,
    input logic       banks_idle,
    input logic [2:0] cas_lat,
    input logic [2:0] wr_recovery,
    input logic       test_mode,
    input logic [1:0] ca_term,
    input logic [1:0] term_mode,
    input logic       add_lat,
    input logic       strobe_single,
    input logic       dll_on,
    input logic [2:0] drv_sel,
    input logic       rd_term_off,
    input logic [3:0] read_lat,
    input logic [1:0] write_lat,
    input logic       busy,
    input logic       illegal_mode,
    input logic       mode_valid
);
    logic        wr_cmd;
    logic [17:0] cfg;

    assign wr_cmd = !cs_n && !ras_n && !cas_n && !we_n;
    assign cfg = {cas_lat, wr_recovery, test_mode, ca_term, term_mode, add_lat,
                  strobe_single, dll_on, drv_sel, rd_term_off};

    // R1
    no_spurious_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cmd |=> !$rose(busy));

    // R1
    nonwrite_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cmd |=> $stable(cfg));

    // R3
    cl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_lat >= 3'd5));

    // R5
    wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_recovery >= 3'd3) && (wr_recovery <= 3'd5));

    // R8
    latency_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        read_lat == ({1'b0, cas_lat} + {2'b00, write_lat} - 4'd1));

    // R9
    not_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !banks_idle |=> $stable(cfg));

    // R10
    busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_cmd) |=> $stable(cfg));

    // R10
    busy_min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy);

    // R11
    illegal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_mode |=> illegal_mode);

    // R12
    valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_valid |=> mode_valid);
endmodule

bind mrs_prog_unit mrs_prog_unit_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cs_n          (cs_n),
    .ras_n         (ras_n),
    .cas_n         (cas_n),
    .we_n          (we_n),
    .banks_idle    (banks_idle),
    .cas_lat       (cas_lat),
    .wr_recovery   (wr_recovery),
    .test_mode     (test_mode),
    .ca_term       (ca_term),
    .term_mode     (term_mode),
    .add_lat       (add_lat),
    .strobe_single (strobe_single),
    .dll_on        (dll_on),
    .drv_sel       (drv_sel),
    .rd_term_off   (rd_term_off),
    .read_lat      (read_lat),
    .write_lat     (write_lat),
    .busy          (busy),
    .illegal_mode  (illegal_mode),
    .mode_valid    (mode_valid)
);

// File: tb/mrs_prog_unit_tb.sv
`timescale 1ns/1ps
module mrs_prog_unit_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic ba_sel = 1'b0;
    logic [11:0] addr = '0;
    logic banks_idle = 1'b1;
    logic [2:0] cas_lat, wr_recovery, drv_sel;
    logic test_mode, add_lat, strobe_single, dll_on, rd_term_off;
    logic [1:0] ca_term, term_mode, write_lat;
    logic [3:0] read_lat;
    logic busy, illegal_mode, mode_valid;

    int n_tests = 0;
    int n_fail = 0;

    // reference model state
    int e_cl, e_wr, e_tm, e_ca, e_term, e_al, e_ss, e_dll, e_drv, e_rto;
    int e_ill, e_sm, e_se, e_blk;

    always #2.5 clk = ~clk;

    mrs_prog_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba_sel(ba_sel), .addr(addr), .banks_idle(banks_idle),
        .cas_lat(cas_lat), .wr_recovery(wr_recovery), .test_mode(test_mode),
        .ca_term(ca_term), .term_mode(term_mode), .add_lat(add_lat),
        .strobe_single(strobe_single), .dll_on(dll_on), .drv_sel(drv_sel),
        .rd_term_off(rd_term_off), .read_lat(read_lat), .write_lat(write_lat),
        .busy(busy), .illegal_mode(illegal_mode), .mode_valid(mode_valid)
    );

    function automatic int cl_of(input logic [2:0] c);
        return (c == 3'b101) ? 5 : (c == 3'b110) ? 6 : (c == 3'b111) ? 7 : 0;
    endfunction

    function automatic int twr_of(input logic [2:0] c);
        return (c == 3'b010) ? 3 : (c == 3'b011) ? 4 : (c == 3'b100) ? 5 : 0;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        e_cl = 5; e_wr = 3; e_tm = 0; e_ca = 0; e_term = 0; e_al = 0; e_ss = 0;
        e_dll = 0; e_drv = 0; e_rto = 0; e_ill = 0; e_sm = 0; e_se = 0; e_blk = 0;
    endtask

    task automatic compare_all();
        check("R3 cas_lat", cas_lat, e_cl);
        check("R5 wr_recovery", wr_recovery, e_wr);
        check("R6 test_mode", test_mode, e_tm);
        check("R7 ca_term", ca_term, e_ca);
        check("R7 term_mode", term_mode, e_term);
        check("R7 add_lat", add_lat, e_al);
        check("R7 strobe_single", strobe_single, e_ss);
        check("R7 dll_on", dll_on, e_dll);
        check("R7 drv_sel", drv_sel, e_drv);
        check("R7 rd_term_off", rd_term_off, e_rto);
        check("R8 read_lat", read_lat, e_cl + e_al);
        check("R8 write_lat", write_lat, e_al + 1);
        check("R10 busy", busy, (e_blk > 0) ? 1 : 0);
        check("R11 illegal_mode", illegal_mode, e_ill);
        check("R12 mode_valid", mode_valid, (e_sm != 0 && e_se != 0) ? 1 : 0);
    endtask

    // drive one cycle; inputs are applied at a falling edge
    task automatic step(input logic [3:0] cmd, input logic ba, input logic idle,
                        input logic [11:0] a);
        logic wr;
        {cs_n, ras_n, cas_n, we_n} = cmd;
        ba_sel = ba; banks_idle = idle; addr = a;
        @(posedge clk);
        wr = (cmd == 4'b0000);
        if (e_blk > 0) begin
            e_blk--;
        end else if (wr && idle) begin
            e_blk = 3;
            if (!ba) begin
                e_sm = 1;
                e_tm = a[7];
                if (cl_of(a[6:4]) != 0) e_cl = cl_of(a[6:4]);
                if (twr_of(a[11:9]) != 0) e_wr = twr_of(a[11:9]);
                if (a[2:0] != 3'b010 || a[3] || cl_of(a[6:4]) == 0 || twr_of(a[11:9]) == 0)
                    e_ill = 1;
            end else begin
                e_se = 1;
                e_ca = a[1:0]; e_term = a[3:2]; e_al = a[4]; e_ss = a[5];
                e_dll = a[6]; e_drv = a[9:7]; e_rto = a[10];
            end
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic nop(input int n);
        for (int i = 0; i < n; i++) step(4'b1111, 1'b0, 1'b1, 12'h000);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        {cs_n, ras_n, cas_n, we_n} = 4'b1111;
        repeat (3) @(posedge clk);
        @(negedge clk);
        model_reset();
        check("R13 reset cas_lat", cas_lat, 5);
        check("R13 reset wr_recovery", wr_recovery, 3);
        check("R13 reset busy", busy, 0);
        check("R13 reset illegal_mode", illegal_mode, 0);
        check("R13 reset mode_valid", mode_valid, 0);
        check("R13 reset options", {test_mode, ca_term, term_mode, add_lat,
              strobe_single, dll_on, drv_sel, rd_term_off}, 0);
        rst_n = 1'b1;
    endtask

    // mode opcode: wr code, test, cl code, bt, bl
    function automatic logic [11:0] mop(input logic [2:0] wrc, input logic tm,
                                        input logic [2:0] clc, input logic bt,
                                        input logic [2:0] bl);
        return {wrc, 1'b0, tm, clc, bt, bl};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        do_reset();

        // R2: extended write, primary untouched, valid still low
        step(4'b0000, 1'b1, 1'b1, 12'b0_1_101_1_1_1_11_10);
        check("R2 ext write keeps cas_lat", cas_lat, 5);
        check("R12 valid low after one register", mode_valid, 0);
        nop(4);
        // primary write CL=6, tWR=4: RL=7, WL=2
        step(4'b0000, 1'b0, 1'b1, mop(3'b011, 1'b0, 3'b110, 1'b0, 3'b010));
        check("R8 read_lat with AL=1", read_lat, 7);
        check("R8 write_lat with AL=1", write_lat, 2);
        check("R2 primary write keeps drv_sel", drv_sel, 5);
        check("R12 valid after both", mode_valid, 1);
        // R10: writes at k+1..k+3 ignored, k+4 accepted
        for (int i = 0; i < 3; i++)
            step(4'b0000, 1'b0, 1'b1, mop(3'b011, 1'b0, 3'b111, 1'b0, 3'b010));
        check("R10 write inside window ignored", cas_lat, 6);
        step(4'b0000, 1'b0, 1'b1, mop(3'b011, 1'b0, 3'b111, 1'b0, 3'b010));
        check("R10 write at k+4 accepted", cas_lat, 7);
        nop(4);
        // R1: a different command pattern has no effect
        step(4'b0001, 1'b0, 1'b1, mop(3'b010, 1'b1, 3'b101, 1'b0, 3'b010));
        check("R1 non-write pattern ignored", cas_lat, 7);
        check("R1 no busy on non-write", busy, 0);
        step(4'b1000, 1'b1, 1'b1, 12'h7FF);
        check("R1 deselected ignored", drv_sel, 5);
        // R9: banks not idle
        step(4'b0000, 1'b0, 1'b0, mop(3'b010, 1'b0, 3'b101, 1'b0, 3'b010));
        check("R9 write while banks busy ignored", cas_lat, 7);
        nop(1);
        // R4: bad burst length, CL still updates
        step(4'b0000, 1'b0, 1'b1, mop(3'b100, 1'b0, 3'b101, 1'b0, 3'b011));
        check("R4 bad burst flags illegal", illegal_mode, 1);
        check("R4 legal CL still updates", cas_lat, 5);
        check("R4 legal tWR still updates", wr_recovery, 5);
        nop(6);
        check("R11 illegal stays set", illegal_mode, 1);

        do_reset();
        // R4: burst type must be sequential
        step(4'b0000, 1'b0, 1'b1, mop(3'b010, 1'b0, 3'b110, 1'b1, 3'b010));
        check("R4 interleaved type flags illegal", illegal_mode, 1);
        check("R4 CL updates alongside bad type", cas_lat, 6);

        do_reset();
        // R3: reserved CL keeps previous value
        step(4'b0000, 1'b0, 1'b1, mop(3'b011, 1'b1, 3'b100, 1'b0, 3'b010));
        check("R3 reserved CL keeps value", cas_lat, 5);
        check("R3 reserved CL flags illegal", illegal_mode, 1);
        check("R6 test mode set", test_mode, 1);
        nop(4);
        // R5: reserved tWR keeps value
        step(4'b0000, 1'b0, 1'b1, mop(3'b111, 1'b0, 3'b111, 1'b0, 3'b010));
        check("R5 reserved tWR keeps value", wr_recovery, 4);
        check("R3 legal CL 7", cas_lat, 7);

        // random traffic
        for (int r = 0; r < 4; r++) begin
            do_reset();
            for (int i = 0; i < 1500; i++) begin
                logic [3:0]  cmd;
                logic [11:0] a;
                cmd = (($urandom % 10) < 5) ? 4'b0000 : 4'($urandom);
                a = 12'($urandom);
                if (($urandom % 100) < 85) a[3:0] = 4'b0010;
                if (($urandom % 100) < 70) a[6] = 1'b1;
                step(cmd, 1'($urandom), (($urandom % 8) != 0), a);
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule